// File: doc/BRIEF.md
# UART Interrupt Source Generator

This block turns the status of a serial port into interrupt requests. It watches the fill levels of the transmit and receive queues, the single-entry holding and receive buffers used when queueing is off, and the modem flow-control lines. A per-bit-period tick drives a receive idle timer. From these inputs it keeps four interrupt sources: transmit, receive, modem change and receive timeout. Each source has its own enable bit. The block drives one output per enabled source and a combined request that an interrupt controller can take as a single line.

A mode input selects between queue mode and single-buffer mode. Each data source uses a different set and clear rule in each mode. Software loads the four enables with a write strobe. It reads the sources before masking on one status bus and after masking on another. The queue storage, the serializer and the baud generator are outside the block and reach it only through its inputs.

Top module: `uart_irq_gen`

## Requirements
- R1: A pulse on `en_wr` loads `en_wdata` into the enable register. The bit positions are tx=0, rx=1, modem=2, timeout=3, and `raw_status` and `masked_status` use the same positions. `masked_status` equals `raw_status` AND the enables, and `irq_tx`, `irq_rx`, `irq_ms` and `irq_rto` are the four masked bits.
- R2: `irq_any` is high exactly when at least one bit of `masked_status` is high.
- R3: In queue mode (`fifo_en`=1) the transmit source is set one cycle after `tx_level` is below half depth (8). It is cleared one cycle after `tx_level` is above 8. At a level of exactly 8 it keeps its value.
- R4: In single-buffer mode the transmit source follows `thr_empty` one cycle later. A `thr_wr` pulse clears it in the next cycle, even when `thr_empty` is high.
- R5: In queue mode the receive source is high one cycle after `rx_level` is at or above 8, and low one cycle after `rx_level` is below 8.
- R6: In single-buffer mode the receive source follows `rbr_full` one cycle later. An `rbr_rd` pulse clears it in the next cycle.
- R7: Each modem line passes through two synchronizing flops. Any change of the synchronized lines sets the modem source three clock edges after the input change. The source stays set until a `ms_wr` pulse clears it. A change arriving in the same cycle as the clear wins.
- R8: While `rx_level` is non-zero, 32 `bit_tick` pulses with no `rx_push` set the timeout source. After 31 such ticks it is still clear.
- R9: An `rx_push` restarts the idle count from zero. The count saturates at 32, so further ticks keep the source set.
- R10: Once set, the timeout source stays set through further pushes and partial reads. It clears in the cycle after `rx_level` reaches 0.
- R11: `raw_status` reports every source regardless of its enable bit.
- R12: A synchronous active-high `rst` clears the enables, the idle count, the modem flag and all sources, so after reset `raw_status`, `masked_status` and `irq_any` are zero while the inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = queue mode, 0 = single-buffer mode |
| tx_level | input | 5 | Transmit queue fill level |
| rx_level | input | 5 | Receive queue fill level |
| rx_push | input | 1 | A new character entered the receive queue |
| thr_empty | input | 1 | Transmit holding buffer empty (single-buffer mode) |
| thr_wr | input | 1 | Software wrote the holding buffer |
| rbr_full | input | 1 | Receive buffer full (single-buffer mode) |
| rbr_rd | input | 1 | Software read the receive buffer |
| ms_wr | input | 1 | Software wrote the modem status register |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 4 | Enable bits to load |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| modem_in | input | 4 | Asynchronous flow-control lines |
| raw_status | output | 4 | Sources before masking |
| masked_status | output | 4 | Sources after masking |
| irq_tx | output | 1 | Enabled transmit request |
| irq_rx | output | 1 | Enabled receive request |
| irq_ms | output | 1 | Enabled modem-change request |
| irq_rto | output | 1 | Enabled receive-timeout request |
| irq_any | output | 1 | OR of the enabled requests |

## Verification
The assertions assume that `tx_level` and `rx_level` never exceed the queue depth. They also assume that `bit_tick` and the software strobes are single-cycle pulses sampled on the clock. The bench drives every input on the falling edge and keeps the levels within 0 to 16. It changes `modem_in` only between checks, so the three-edge synchronizer latency is observed at a known cycle. All modem lines are held at zero through reset, so no spurious change is seen when reset is released.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC    = 4;
  localparam int BIT_TX  = 0;
  localparam int BIT_RX  = 1;
  localparam int BIT_MS  = 2;
  localparam int BIT_RTO = 3;
endpackage

// File: rtl/uart_irq_level_src.sv
module uart_irq_level_src #(
  parameter int LVL_W = 5,
  parameter int HALF  = 8,
  parameter bit IS_TX = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] level,
  input  logic             buf_flag,
  input  logic             sw_strobe,
  output logic             src_q
);
  localparam logic [LVL_W-1:0] HALF_L = LVL_W'(HALF);

  logic fifo_next;

  generate
    if (IS_TX) begin : g_tx
      always_comb begin
        if (level < HALF_L)      fifo_next = 1'b1;
        else if (level > HALF_L) fifo_next = 1'b0;
        else                     fifo_next = src_q;
      end
    end else begin : g_rx
      always_comb fifo_next = (level >= HALF_L);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          src_q <= 1'b0;
    else if (fifo_en) src_q <= fifo_next;
    else              src_q <= sw_strobe ? 1'b0 : buf_flag;
  end
endmodule

// File: rtl/uart_irq_modem_det.sv
module uart_irq_modem_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lines,
  input  logic         clr,
  output logic         flag_q
);
  logic [W-1:0] s1_q, s2_q, prev_q;
  logic         changed;

  always_comb changed = (s2_q != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      s1_q   <= lines;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (changed)  flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_rx_timeout.sv
module uart_irq_rx_timeout #(
  parameter int LVL_W = 5,
  parameter int LIMIT = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             bit_tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q
);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

  logic empty;
  always_comb empty = (rx_level == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (rx_push || empty)              cnt_q <= '0;
      else if (bit_tick && cnt_q != LIM_C) cnt_q <= cnt_q + 1'b1;
      if (empty)               flag_q <= 1'b0;
      else if (cnt_q == LIM_C) flag_q <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
  parameter int DEPTH    = 16,
  parameter int TMO_BITS = 32,
  parameter int MS_W     = 4,
  parameter int LVL_W    = $clog2(DEPTH + 1),
  parameter int CNT_W    = $clog2(TMO_BITS + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          fifo_en,
  input  logic [LVL_W-1:0]              tx_level,
  input  logic [LVL_W-1:0]              rx_level,
  input  logic                          rx_push,
  input  logic                          thr_empty,
  input  logic                          thr_wr,
  input  logic                          rbr_full,
  input  logic                          rbr_rd,
  input  logic                          ms_wr,
  input  logic                          en_wr,
  input  logic [uart_irq_pkg::NSRC-1:0] en_wdata,
  input  logic                          bit_tick,
  input  logic [MS_W-1:0]               modem_in,
  output logic [uart_irq_pkg::NSRC-1:0] raw_status,
  output logic [uart_irq_pkg::NSRC-1:0] masked_status,
  output logic                          irq_tx,
  output logic                          irq_rx,
  output logic                          irq_ms,
  output logic                          irq_rto,
  output logic                          irq_any
);
  import uart_irq_pkg::*;

  localparam int HALF = DEPTH / 2;

  logic [NSRC-1:0]  en_q;
  logic [CNT_W-1:0] idle_cnt;
  logic             tx_src, rx_src, ms_src, rto_src;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  uart_irq_level_src #(.LVL_W(LVL_W), .HALF(HALF), .IS_TX(1'b1)) tx_src_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .level(tx_level),
    .buf_flag(thr_empty), .sw_strobe(thr_wr), .src_q(tx_src));

  uart_irq_level_src #(.LVL_W(LVL_W), .HALF(HALF), .IS_TX(1'b0)) rx_src_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .level(rx_level),
    .buf_flag(rbr_full), .sw_strobe(rbr_rd), .src_q(rx_src));

  uart_irq_modem_det #(.W(MS_W)) ms_i (
    .clk(clk), .rst(rst), .lines(modem_in), .clr(ms_wr), .flag_q(ms_src));

  uart_irq_rx_timeout #(.LVL_W(LVL_W), .LIMIT(TMO_BITS), .CNT_W(CNT_W)) rto_i (
    .clk(clk), .rst(rst), .rx_level(rx_level), .rx_push(rx_push),
    .bit_tick(bit_tick), .cnt_q(idle_cnt), .flag_q(rto_src));

  always_comb begin
    raw_status          = '0;
    raw_status[BIT_TX]  = tx_src;
    raw_status[BIT_RX]  = rx_src;
    raw_status[BIT_MS]  = ms_src;
    raw_status[BIT_RTO] = rto_src;
    masked_status       = raw_status & en_q;
    irq_tx              = masked_status[BIT_TX];
    irq_rx              = masked_status[BIT_RX];
    irq_ms              = masked_status[BIT_MS];
    irq_rto             = masked_status[BIT_RTO];
    irq_any             = |masked_status;
  end
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
  parameter int DEPTH    = 16,
  parameter int TMO_BITS = 32,
  parameter int LVL_W    = 5,
  parameter int CNT_W    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_en,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             thr_wr,
  input logic             rbr_rd,
  input logic             en_wr,
  input logic [3:0]       en_wdata,
  input logic [3:0]       raw_status,
  input logic [3:0]       masked_status,
  input logic             irq_any,
  input logic [CNT_W-1:0] idle_cnt
);
  localparam logic [LVL_W-1:0] HALF_L = LVL_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] LIM_C  = CNT_W'(TMO_BITS);

  // R1
  en_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (en_wr && en_wdata == 4'b0) |=> masked_status == 4'b0);
  // R2
  any_high_chk: assert property (@(posedge clk) disable iff (rst)
    irq_any |-> masked_status != 4'b0);
  // R2
  any_low_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_any |-> masked_status == 4'b0);
  // R3
  tx_set_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && tx_level < HALF_L) |=> raw_status[0]);
  // R3
  tx_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && tx_level > HALF_L) |=> !raw_status[0]);
  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && tx_level == HALF_L) |=> raw_status[0] == $past(raw_status[0]));
  // R4
  thr_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && thr_wr) |=> !raw_status[0]);
  // R5
  rx_half_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && rx_level >= HALF_L) |=> raw_status[1]);
  // R6
  rbr_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && rbr_rd) |=> !raw_status[1]);
  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    idle_cnt <= LIM_C);
  // R10
  rto_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |=> !raw_status[3]);
endmodule

bind uart_irq_gen uart_irq_chk #(
  .DEPTH(DEPTH), .TMO_BITS(TMO_BITS), .LVL_W(LVL_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_level(tx_level),
  .rx_level(rx_level), .thr_wr(thr_wr), .rbr_rd(rbr_rd), .en_wr(en_wr),
  .en_wdata(en_wdata), .raw_status(raw_status), .masked_status(masked_status),
  .irq_any(irq_any), .idle_cnt(idle_cnt)
);

// File: tb/uart_irq_gen_tb.sv
module uart_irq_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b0;
  logic [4:0] tx_level = '0, rx_level = '0;
  logic       rx_push = 1'b0, thr_empty = 1'b0, thr_wr = 1'b0;
  logic       rbr_full = 1'b0, rbr_rd = 1'b0, ms_wr = 1'b0, en_wr = 1'b0;
  logic [3:0] en_wdata = '0;
  logic       bit_tick = 1'b0;
  logic [3:0] modem_in = '0;
  logic [3:0] raw_status, masked_status;
  logic       irq_tx, irq_rx, irq_ms, irq_rto, irq_any;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  uart_irq_gen dut_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_level(tx_level),
    .rx_level(rx_level), .rx_push(rx_push), .thr_empty(thr_empty),
    .thr_wr(thr_wr), .rbr_full(rbr_full), .rbr_rd(rbr_rd), .ms_wr(ms_wr),
    .en_wr(en_wr), .en_wdata(en_wdata), .bit_tick(bit_tick),
    .modem_in(modem_in), .raw_status(raw_status),
    .masked_status(masked_status), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_ms(irq_ms), .irq_rto(irq_rto), .irq_any(irq_any));

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_en(input logic [3:0] v);
    en_wdata = v; en_wr = 1'b1; cyc(1); en_wr = 1'b0; cyc(1);
  endtask

  // one tick pulse, ends two falling edges later
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; cyc(1); bit_tick = 1'b0; cyc(1);
    end
  endtask

  task automatic push;
    rx_push = 1'b1; cyc(1); rx_push = 1'b0; cyc(1);
  endtask

  task automatic t_reset;
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(2);
    check("R12 raw after reset", 32'(raw_status), 32'h0);
    check("R12 masked after reset", 32'(masked_status), 32'h0);
    check("R12 any after reset", 32'(irq_any), 32'h0);
  endtask

  task automatic t_enable;
    fifo_en = 1'b0; thr_empty = 1'b1; cyc(1);
    check("R11 raw tx with enables off", 32'(raw_status), 32'h1);
    check("R1 masked with enables off", 32'(masked_status), 32'h0);
    set_en(4'b0001);
    check("R1 irq_tx enabled", 32'(irq_tx), 32'h1);
    check("R2 any follows tx", 32'(irq_any), 32'h1);
    set_en(4'b1110);
    check("R1 tx masked off", 32'(masked_status), 32'h0);
    check("R2 any low", 32'(irq_any), 32'h0);
    set_en(4'b1111);
    thr_wr = 1'b1; cyc(1); thr_wr = 1'b0; thr_empty = 1'b0;
    check("R4 write clears tx", 32'(raw_status[0]), 32'h0);
    cyc(2);
    check("R4 tx stays clear", 32'(irq_tx), 32'h0);
  endtask

  task automatic t_tx_fifo;
    fifo_en = 1'b1; tx_level = 5'd3; cyc(1);
    check("R3 tx below half", 32'(irq_tx), 32'h1);
    tx_level = 5'd8; cyc(2);
    check("R3 hold high at half", 32'(irq_tx), 32'h1);
    tx_level = 5'd9; cyc(1);
    check("R3 clear above half", 32'(irq_tx), 32'h0);
    tx_level = 5'd8; cyc(2);
    check("R3 hold low at half", 32'(irq_tx), 32'h0);
    tx_level = 5'd7; cyc(1);
    check("R3 set again", 32'(irq_tx), 32'h1);
    tx_level = 5'd16; cyc(1);
  endtask

  task automatic t_rx;
    fifo_en = 1'b1; rx_level = 5'd7; cyc(1);
    check("R5 below half", 32'(irq_rx), 32'h0);
    rx_level = 5'd8; cyc(1);
    check("R5 at half", 32'(irq_rx), 32'h1);
    rx_level = 5'd15; cyc(1);
    check("R5 above half", 32'(irq_rx), 32'h1);
    rx_level = 5'd7; cyc(1);
    check("R5 drained below half", 32'(irq_rx), 32'h0);
    rx_level = 5'd0; fifo_en = 1'b0; rbr_full = 1'b1; cyc(1);
    check("R6 buffer full", 32'(irq_rx), 32'h1);
    rbr_rd = 1'b1; cyc(1); rbr_rd = 1'b0; rbr_full = 1'b0;
    check("R6 read clears", 32'(irq_rx), 32'h0);
    cyc(1);
    check("R6 stays clear", 32'(irq_rx), 32'h0);
  endtask

  task automatic t_modem;
    modem_in = 4'b0010; cyc(2);
    check("R7 not yet after two edges", 32'(raw_status[2]), 32'h0);
    cyc(1);
    check("R7 set after three edges", 32'(raw_status[2]), 32'h1);
    cyc(3);
    check("R7 sticky", 32'(irq_ms), 32'h1);
    ms_wr = 1'b1; cyc(1); ms_wr = 1'b0;
    check("R7 write clears", 32'(irq_ms), 32'h0);
    modem_in = 4'b0000; cyc(4);
    check("R7 fall also detected", 32'(irq_ms), 32'h1);
    check("R2 any from modem", 32'(irq_any), 32'h1);
    ms_wr = 1'b1; cyc(1); ms_wr = 1'b0; cyc(1);
    check("R7 cleared again", 32'(irq_ms), 32'h0);
  endtask

  task automatic t_timeout;
    fifo_en = 1'b1; rx_level = 5'd2; push();
    tick(31); cyc(2);
    check("R8 clear after 31 ticks", 32'(irq_rto), 32'h0);
    tick(1);
    check("R8 set after 32 ticks", 32'(irq_rto), 32'h1);
    rx_level = 5'd3; push();
    check("R10 stays set on push", 32'(irq_rto), 32'h1);
    rx_level = 5'd1; cyc(2);
    check("R10 stays set on partial read", 32'(irq_rto), 32'h1);
    rx_level = 5'd0; cyc(1);
    check("R10 clears when empty", 32'(irq_rto), 32'h0);
    rx_level = 5'd2; push();
    tick(20); push(); tick(20); cyc(2);
    check("R9 push restarts count", 32'(irq_rto), 32'h0);
    tick(12);
    check("R9 set after restart", 32'(irq_rto), 32'h1);
    tick(40);
    check("R9 saturated stays set", 32'(irq_rto), 32'h1);
    rx_level = 5'd0; cyc(2);
    check("R10 cleared at end", 32'(raw_status[3]), 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    t_reset();
    t_enable();
    t_tx_fifo();
    t_rx();
    t_modem();
    t_timeout();
    finish_run();
  end
endmodule